// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave (SMBus Write)

This block is the write-only serial configuration port of a clock generator. It watches the two-wire SMBus lines, SCL and SDA, using the fast system clock. It finds start and stop conditions and checks the 7-bit device address. It acknowledges each byte that belongs to it and stores incoming data bytes in a bank of six 8-bit control registers. The stored bits drive the generator's output controls. These controls are two 48/24 MHz selects, per-output enables for the CPU, PCI, SDRAM, USB/IO, APIC and reference clocks, and a three-state request and a test-mode request.

A write always fills the registers in order, starting at register 0 for every new transaction, and each byte is shifted in most significant bit first. A byte reaches its register only after all eight bits have arrived. Bits without a function are held at zero, whatever value is written to them. Reset loads every enable as active and both frequency selects as 48 MHz.

Control is centred on one state machine with six states:
- IDLE waits for a start.
- ADDR shifts in the address byte.
- ADDR_ACK pulls SDA low for the acknowledge slot.
- DATA shifts in a data byte.
- DATA_ACK acknowledges the byte and commits it.
- SKIP ignores the bus until the next start or stop.

The transitions are:
- A start moves any state to ADDR.
- A stop moves any state to IDLE.
- ADDR goes to ADDR_ACK when the address matches and R/W is 0. Otherwise it goes to SKIP.
- ADDR_ACK goes to DATA on the falling SCL edge that ends the acknowledge.
- DATA goes to DATA_ACK on the falling edge after eight bits. The byte is committed on this transition.
- DATA_ACK goes back to DATA on the next falling edge.

Top module: `clkcfg_smb_slave`

## Requirements
- R1: After reset, register bytes 0 to 5 read 0x0C, 0xCF, 0x7F, 0xFF, 0x00 and 0x13, and `sda_oe` is 0.
- R2: A first byte of 0xD2 (address 1101001, R/W = 0) is acknowledged: `sda_oe` is 1 during the ninth SCL high phase.
- R3: A first byte with any other address gets no acknowledge. Neither do the bytes that follow it, and the registers do not change.
- R4: The data bytes of a write go to registers 0, 1, 2 and onward in arrival order, starting again at register 0 in every transaction. The first bit of each byte received is bit 7.
- R5: Every data byte of an addressed write is acknowledged.
- R6: Only writable bits store the written value. The writable masks are 0x0F for byte 0, 0xCF for byte 1, 0x7F for byte 2, 0xFF for byte 3, 0x00 for byte 4 and 0x13 for byte 5. All other bits stay 0.
- R7: Data bytes after the sixth are acknowledged and discarded, and the registers do not change.
- R8: A byte cut short by a stop or a start before its eighth bit does not change any register.
- R9: The field outputs map to the register bits as follows. The output is 1 when enabled or selected.
  - `usb_sel[1]` is byte 0 bit 3, and `usb_sel[0]` is byte 0 bit 2 (1 = 48 MHz).
  - `tristate_req` is byte 0 bit 1, and `test_req` is byte 0 bit 0.
  - `usbio_en` is byte 1 bits 7:6, and `cpu_en` is byte 1 bits 3:0.
  - `pci_en` is byte 2 bits 6:0, with bit 6 as the free-running PCI clock.
  - `sdram_en` is byte 3.
  - `apic_en` is byte 5 bit 4, and `ref_en` is byte 5 bits 1:0.
- R10: A first byte of 0xD3 (the device address with R/W = 1) is not acknowledged.
- R11: A start in the middle of a transaction restarts the address phase. The data bytes that follow land again from register 0.
- R12: `sda_oe` is 1 only in acknowledge slots. It only rises while SCL is low, and it is 0 the cycle after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SMBus clock line as seen at the pad |
| sda_in | input | 1 | SMBus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| cfg_image | output | 48 | All six register bytes, byte k at bits 8k+7:8k |
| usb_sel | output | 2 | 48 MHz (1) or 24 MHz (0) select per USB/IO output |
| tristate_req | output | 1 | Request to float all clock outputs |
| test_req | output | 1 | Request for test mode |
| usbio_en | output | 2 | USB/IO output enables |
| cpu_en | output | 4 | CPU clock enables |
| pci_en | output | 7 | PCI clock enables, bit 6 free-running clock |
| sdram_en | output | 8 | SDRAM clock enables |
| apic_en | output | 1 | APIC clock enable |
| ref_en | output | 2 | Reference clock enables |

## Verification
The bench builds the block with its default address, 1101001. This lets it probe both a neighbouring wrong address and the same address with the read bit set. The bit phase is eight system clocks per quarter of the SCL period. At that rate the two-flop synchronizer and the registered outputs settle well inside each SCL phase, so the bench can sample the acknowledge in mid-high phase. Six registers, one of them entirely unused, let a seven-byte write reach the discard path. The same write checks every mask, including the all-zero one.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    localparam int NUM_REGS = 6;
    localparam int CFG_W    = NUM_REGS * 8;
    localparam int IDX_W    = $clog2(NUM_REGS + 1);
    localparam int BIT_W    = 4;

    // byte positions decoded by the output field mapping
    localparam int B_MODE   = 0;
    localparam int B_CPU    = 1;
    localparam int B_PCI    = 2;
    localparam int B_SDR    = 3;
    localparam int B_PERI   = 5;

    // writable bits per byte (index 5 leftmost)
    localparam logic [NUM_REGS-1:0][7:0] REG_MASK =
        {8'h13, 8'h00, 8'hFF, 8'h7F, 8'hCF, 8'h0F};
    // reset value per byte
    localparam logic [NUM_REGS-1:0][7:0] REG_RST =
        {8'h13, 8'h00, 8'hFF, 8'h7F, 8'hCF, 8'h0C};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q, scl_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_now   = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_now & ~scl_q;
    assign scl_fall  = ~scl_now & scl_q;
    assign start_det = scl_now & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_now & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_wr_fsm.sv
module smb_wr_fsm
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data
);
    smb_state_e st, nxt;
    logic [7:0]       shreg;
    logic [BIT_W-1:0] bit_cnt;
    logic [IDX_W-1:0] idx;
    logic bit_full, addr_hit, commit, in_ack;

    assign bit_full = (bit_cnt == BIT_W'(8));
    assign addr_hit = (shreg[7:1] == DEV_ADDR) && !shreg[0];
    assign commit   = (st == ST_DATA) && scl_fall && bit_full;
    assign in_ack   = (st == ST_ADDR_ACK) || (st == ST_DATA_ACK);

    always_comb begin
        nxt = st;
        if (start_det)     nxt = ST_ADDR;
        else if (stop_det) nxt = ST_IDLE;
        else begin
            unique case (st)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (scl_fall && bit_full) nxt = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall) nxt = ST_DATA;
                ST_DATA:     if (scl_fall && bit_full) nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) nxt = ST_DATA;
                ST_SKIP:     nxt = ST_SKIP;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // shift register, bit counter, byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            idx     <= '0;
        end else begin
            if (start_det || (scl_fall && in_ack)) begin
                bit_cnt <= '0;
            end else if (scl_rise && (st == ST_ADDR || st == ST_DATA) && !bit_full) begin
                shreg   <= {shreg[6:0], sda_s};
                bit_cnt <= bit_cnt + BIT_W'(1);
            end
            if (start_det)
                idx <= '0;
            else if (commit && idx != IDX_W'(NUM_REGS))
                idx <= idx + IDX_W'(1);
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            sda_oe  <= (nxt == ST_ADDR_ACK) || (nxt == ST_DATA_ACK);
            wr_en   <= commit && (idx < IDX_W'(NUM_REGS)) && !start_det && !stop_det;
            wr_idx  <= idx;
            wr_data <= shreg;
        end
    end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import clkcfg_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [7:0]                   wr_data,
    output logic [NUM_REGS-1:0][7:0]     regs_q
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_q[i] <= REG_RST[i];
            else if (wr_en && wr_idx == IDX_W'(i))
                regs_q[i] <= wr_data & REG_MASK[i];
        end
    end
endmodule

// File: rtl/clkcfg_smb_slave.sv
module clkcfg_smb_slave
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    output logic [CFG_W-1:0] cfg_image,
    output logic [1:0]       usb_sel,
    output logic             tristate_req,
    output logic             test_req,
    output logic [1:0]       usbio_en,
    output logic [3:0]       cpu_en,
    output logic [6:0]       pci_en,
    output logic [7:0]       sdram_en,
    output logic             apic_en,
    output logic [1:0]       ref_en
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0] wr_data;
    logic [NUM_REGS-1:0][7:0] regs_q;

    smb_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_wr_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    cfg_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .regs_q(regs_q)
    );

    assign cfg_image    = regs_q;
    assign usb_sel      = regs_q[B_MODE][3:2];
    assign tristate_req = regs_q[B_MODE][1];
    assign test_req     = regs_q[B_MODE][0];
    assign usbio_en     = regs_q[B_CPU][7:6];
    assign cpu_en       = regs_q[B_CPU][3:0];
    assign pci_en       = regs_q[B_PCI][6:0];
    assign sdram_en     = regs_q[B_SDR];
    assign apic_en      = regs_q[B_PERI][4];
    assign ref_en       = regs_q[B_PERI][1:0];
endmodule

// File: rtl/clkcfg_smb_chk.sv
module clkcfg_smb_chk
    import clkcfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_in,
    input logic             stop_det,
    input logic             sda_oe,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [CFG_W-1:0] cfg_image
);
    // R12
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_in);

    // R12
    oe_release_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_image & ~REG_MASK) == '0);

    // R8
    image_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_image));

    // R7
    commit_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDX_W'(NUM_REGS)));
endmodule

bind clkcfg_smb_slave clkcfg_smb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .stop_det(stop_det),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .cfg_image(cfg_image)
);

// File: tb/clkcfg_smb_slave_bench.sv
module clkcfg_smb_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int QTR = 8;
    localparam int NREG = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, sda_drv = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [47:0] cfg_image;
    logic [1:0] usb_sel, usbio_en, ref_en;
    logic tristate_req, test_req, apic_en;
    logic [3:0] cpu_en;
    logic [6:0] pci_en;
    logic [7:0] sdram_en;

    int n_chk = 0, n_bad = 0;
    logic [7:0] exp_r [NREG];

    assign sda_line = sda_drv & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkcfg_smb_slave u_clkcfg_smb_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .cfg_image(cfg_image), .usb_sel(usb_sel),
        .tristate_req(tristate_req), .test_req(test_req), .usbio_en(usbio_en),
        .cpu_en(cpu_en), .pci_en(pci_en), .sdram_en(sdram_en),
        .apic_en(apic_en), .ref_en(ref_en)
    );

    // writable masks as stated in R6
    function automatic logic [7:0] wmask(int k);
        case (k)
            0: return 8'h0F;
            1: return 8'hCF;
            2: return 8'h7F;
            3: return 8'hFF;
            4: return 8'h00;
            default: return 8'h13;
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic qwait();
        #(CLK_PERIOD*QTR);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; qwait();
        scl = 1'b1; qwait();
        sda_drv = 1'b0; qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; qwait();
        scl = 1'b1; qwait();
        sda_drv = 1'b1; qwait(); qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b; qwait();
        scl = 1'b1; qwait(); qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic get_ack(output logic ack);
        sda_drv = 1'b1; qwait();
        scl = 1'b1; qwait();
        ack = ~sda_line;
        qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        get_ack(ack);
    endtask

    function automatic logic [47:0] exp_image();
        logic [47:0] v;
        for (int k = 0; k < NREG; k++) v[k*8 +: 8] = exp_r[k];
        return v;
    endfunction

    task automatic check_image(input string req);
        check(cfg_image == exp_image(), req, {16'h0, cfg_image}, {16'h0, exp_image()});
        check(sda_oe == 1'b0, "R12 idle release", {63'h0, sda_oe}, 64'h0);
    endtask

    task automatic check_fields();
        check(usb_sel == exp_r[0][3:2], "R9 usb_sel", {62'h0, usb_sel}, {62'h0, exp_r[0][3:2]});
        check(tristate_req == exp_r[0][1] && test_req == exp_r[0][0], "R9 tristate/test",
              {62'h0, tristate_req, test_req}, {62'h0, exp_r[0][1:0]});
        check(usbio_en == exp_r[1][7:6] && cpu_en == exp_r[1][3:0], "R9 usbio/cpu",
              {58'h0, usbio_en, cpu_en}, {58'h0, exp_r[1][7:6], exp_r[1][3:0]});
        check(pci_en == exp_r[2][6:0] && sdram_en == exp_r[3], "R9 pci/sdram",
              {49'h0, pci_en, sdram_en}, {49'h0, exp_r[2][6:0], exp_r[3]});
        check(apic_en == exp_r[5][4] && ref_en == exp_r[5][1:0], "R9 apic/ref",
              {61'h0, apic_en, ref_en}, {61'h0, exp_r[5][4], exp_r[5][1:0]});
    endtask

    // full write transaction with addressed write; updates model
    task automatic write_txn(input logic [7:0] first, input int n,
                             input logic [7:0][7:0] d, input logic exp_ack, input string req);
        logic ack;
        bus_start();
        send_byte(first, ack);
        check(ack == exp_ack, req, {63'h0, ack}, {63'h0, exp_ack});
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], ack);
            check(ack == exp_ack, (k >= NREG) ? "R7 overflow ack" : (exp_ack ? "R5 data ack" : "R3 data nack"),
                  {63'h0, ack}, {63'h0, exp_ack});
            if (exp_ack && k < NREG) exp_r[k] = d[k] & wmask(k);
        end
        bus_stop();
        qwait();
    endtask

    task automatic t_reset();
        exp_r[0] = 8'h0C; exp_r[1] = 8'hCF; exp_r[2] = 8'h7F;
        exp_r[3] = 8'hFF; exp_r[4] = 8'h00; exp_r[5] = 8'h13;
        check_image("R1 reset image");
        check_fields();
    endtask

    task automatic t_full_write();
        logic [7:0][7:0] d;
        d = '0;
        d[0] = 8'hA6; d[1] = 8'h35; d[2] = 8'h2A; d[3] = 8'h5C; d[4] = 8'hFF; d[5] = 8'hED;
        write_txn(8'hD2, 6, d, 1'b1, "R2 address ack");
        check_image("R4 R6 sequential masked store");
        check_fields();
    endtask

    task automatic t_overflow();
        logic [7:0][7:0] d;
        d = '0;
        d[0] = 8'h09; d[1] = 8'hC3; d[2] = 8'h55; d[3] = 8'h81; d[4] = 8'h00; d[5] = 8'h12; d[6] = 8'h00;
        write_txn(8'hD2, 7, d, 1'b1, "R2 address ack");
        check_image("R7 extra byte discarded");
    endtask

    task automatic t_short_write();
        logic [7:0][7:0] d;
        d = '0;
        d[0] = 8'h0C; d[1] = 8'hCF;
        write_txn(8'hD2, 2, d, 1'b1, "R2 address ack");
        check_image("R4 restart at byte 0");
        check_fields();
    endtask

    task automatic t_wrong_addr();
        logic [7:0][7:0] d;
        d = '0;
        d[0] = 8'h00; d[1] = 8'h00;
        write_txn(8'hD4, 2, d, 1'b0, "R3 address nack");
        check_image("R3 registers unchanged");
    endtask

    task automatic t_read_dir();
        logic [7:0][7:0] d;
        d = '0;
        d[0] = 8'h03;
        write_txn(8'hD3, 1, d, 1'b0, "R10 read nack");
        check_image("R10 registers unchanged");
    endtask

    task automatic t_partial();
        logic ack;
        bus_start();
        send_byte(8'hD2, ack);
        check(ack, "R8 address ack", {63'h0, ack}, 64'h1);
        send_byte(8'h03, ack);
        exp_r[0] = 8'h03;
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        bus_stop();
        qwait();
        check_image("R8 cut byte dropped");
    endtask

    task automatic t_restart();
        logic ack;
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h0E, ack);
        exp_r[0] = 8'h0E;
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_start();
        send_byte(8'hD2, ack);
        check(ack, "R11 address ack after restart", {63'h0, ack}, 64'h1);
        send_byte(8'h44, ack);
        exp_r[0] = 8'h04;
        send_byte(8'h0F, ack);
        exp_r[1] = 8'h0F;
        bus_stop();
        qwait();
        check_image("R11 restart lands at byte 0");
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2;
        #(CLK_PERIOD*5);
        rst_n = 1'b1;
        #(CLK_PERIOD*5);
        t_reset();
        t_full_write();
        t_overflow();
        t_short_write();
        t_wrong_addr();
        t_read_dir();
        t_partial();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule